// File: doc/BRIEF.md
# Link Pulse Burst Transmitter

This block turns a 16-bit auto-negotiation page into one burst of short pulses on a single output wire. A burst has 33 equally spaced slots. Every other slot, starting with the first and ending with the last, holds a timing pulse that is always sent. Each slot between two timing pulses carries one page bit: a pulse for a 1, silence for a 0. Bit 0 goes first. Slot spacing, pulse width and repeat interval are cycle counts set by parameters. The defaults give 62.5 µs slots, 100 ns pulses and a 16 ms repeat at a 250 MHz clock.

A controller starts a burst by strobing `start_i` while `page_i` holds the page. The page is captured on that edge. `busy_o` stays high until the last pulse has ended, and `done_o` then pulses for one cycle. With `auto_rpt_i` high, the block starts another burst by itself a fixed number of cycles after the previous one started. It captures `page_i` again at that moment.

Top module: `flp_burst_tx`

## Requirements
- R1: Slot n (counting from 0 to 32) starts n*SLOT_CYCLES cycles after the first cycle of the burst. A pulse in any slot is high for exactly PULSE_CYCLES cycles from the start of that slot, and `pulse_o` is low for the rest of the slot.
- R2: Slots 0, 2, 4, … 32 always carry a pulse, which gives 17 timing pulses per burst.
- R3: Slot 2i+1 carries a pulse if and only if bit i of the captured page is 1, for i = 0 to 15, so bit 0 is sent first.
- R4: The page is captured on the clock edge that starts a burst. Later changes of `page_i` do not alter the burst in progress.
- R5: A `start_i` strobe while `busy_o` is high is ignored. The burst in progress continues unchanged, and no extra burst follows it.
- R6: `busy_o` rises in the first cycle of a burst and stays high for exactly 32*SLOT_CYCLES+PULSE_CYCLES cycles. `pulse_o` is never high while `busy_o` is low.
- R7: `done_o` is high for exactly the one cycle after `busy_o` falls. A `start_i` in that cycle is accepted and starts the next burst on the following edge.
- R8: While `auto_rpt_i` is high, a new burst starts exactly REPEAT_CYCLES cycles after the previous burst started. That burst uses the value on `page_i` at that moment.
- R9: If `auto_rpt_i` is low when the repeat interval runs out, no further burst starts on its own.
- R10: While `rst_n` is low and after its release, with no start, `pulse_o`, `busy_o` and `done_o` are low.
- R11: If `start_i` arrives in the same cycle that the repeat interval runs out, exactly one burst starts, and it carries `page_i` from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| page_i | input | 16 | Page to send, captured at burst start |
| auto_rpt_i | input | 1 | Enables automatic burst repetition |
| pulse_o | output | 1 | Serial link pulse output |
| busy_o | output | 1 | High while a burst is being sent |
| done_o | output | 1 | One-cycle strobe after a burst ends |

## Verification
Two functions can fall on the same cycle.

- **Start versus repeat.** An external start can land in the exact cycle the repeat interval runs out. The bench counts cycles from the previous start and drives `start_i` with a fresh page in that cycle. It judges the result by checking that the next burst carries the new page and that no second burst follows within one repeat interval once repetition is turned off.
- **End of burst versus next start.** The cycle that raises `done_o` can also accept a new start. The bench chains bursts back to back with the strobe placed in the `done_o` cycle. It checks that `busy_o` returns high on the very next sample and that the new page appears.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int NUM_SLOTS  = 33;
  localparam int PAGE_W     = 16;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
  typedef logic [PAGE_W-1:0]     page_t;
  typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
endpackage

// File: rtl/flp_slot_timer.sv
module flp_slot_timer
  import flp_pkg::*;
#(
  parameter int SLOT_CYCLES  = 15625,
  parameter int PULSE_CYCLES = 25
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      launch_i,
  output logic      busy_o,
  output slot_idx_t slot_o,
  output logic      in_pulse_o,
  output logic      last_o
);
  localparam int CW = $clog2(SLOT_CYCLES);
  localparam logic [CW-1:0] SLOT_LAST  = CW'(SLOT_CYCLES - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYCLES - 1);
  localparam slot_idx_t     SLOT_FINAL = SLOT_IDX_W'(NUM_SLOTS - 1);

  logic [CW-1:0] cyc_q, cyc_d;
  slot_idx_t     slot_q, slot_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  assign cnt_en     = busy_q | launch_i;
  assign last_o     = busy_q && (slot_q == SLOT_FINAL) && (cyc_q == PULSE_LAST);
  assign in_pulse_o = busy_q && (cyc_q <= PULSE_LAST);
  assign busy_o     = busy_q;
  assign slot_o     = slot_q;

  always_comb begin
    busy_d = busy_q;
    cyc_d  = cyc_q;
    slot_d = slot_q;
    if (launch_i) begin
      busy_d = 1'b1;
      cyc_d  = '0;
      slot_d = '0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_d = 1'b0;
      end else if (cyc_q == SLOT_LAST) begin
        cyc_d  = '0;
        slot_d = slot_q + 1'b1;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cyc_q  <= cyc_d;
      slot_q <= slot_d;
    end
  end

  // R1
  slot_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cyc_q <= SLOT_LAST) && (slot_q <= SLOT_FINAL));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> busy_q);

  // R6
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(launch_i));
endmodule

// File: rtl/flp_repeat_timer.sv
module flp_repeat_timer #(
  parameter int REPEAT_CYCLES = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic auto_i,
  input  logic busy_i,
  output logic fire_o
);
  localparam int RW = $clog2(REPEAT_CYCLES);
  localparam logic [RW-1:0] RPT_LAST = RW'(REPEAT_CYCLES - 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          cnt_en;

  assign cnt_en = armed_q | launch_i;
  assign fire_o = armed_q && (cnt_q == RPT_LAST) && auto_i && !busy_i;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (launch_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q) begin
      if (cnt_q == RPT_LAST) armed_d = 1'b0;
      else                   cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R9
  no_fire_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_i |-> !fire_o);
endmodule

// File: rtl/flp_burst_tx.sv
module flp_burst_tx
  import flp_pkg::*;
#(
  parameter int SLOT_CYCLES   = 15625,
  parameter int PULSE_CYCLES  = 25,
  parameter int REPEAT_CYCLES = 4000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] page_i,
  input  logic        auto_rpt_i,
  output logic        pulse_o,
  output logic        busy_o,
  output logic        done_o
);
  page_t     page_q;
  slot_idx_t slot_w;
  logic      busy_w, in_pulse_w, last_w, fire_w, launch_w, done_q, data_bit;

  assign launch_w = !busy_w && (start_i || fire_w);

  flp_slot_timer #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (launch_w),
    .busy_o    (busy_w),
    .slot_o    (slot_w),
    .in_pulse_o(in_pulse_w),
    .last_o    (last_w)
  );

  flp_repeat_timer #(
    .REPEAT_CYCLES(REPEAT_CYCLES)
  ) u_rpt (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(launch_w),
    .auto_i  (auto_rpt_i),
    .busy_i  (busy_w),
    .fire_o  (fire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        page_q <= '0;
    else if (launch_w) page_q <= page_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last_w;
  end

  assign data_bit = page_q[slot_w[4:1]];
  assign pulse_o  = in_pulse_w && (!slot_w[0] || data_bit);
  assign busy_o   = busy_w;
  assign done_o   = done_q;

  // R6
  pulse_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> busy_o);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R4
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(page_q));

  // R5
  start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(page_q));
endmodule

// File: tb/flp_burst_tx_tb.sv
module flp_burst_tx_tb;
  localparam int SLOT  = 20;
  localparam int PULSE = 3;
  localparam int RPT   = 800;
  localparam int BLEN  = 32 * SLOT + PULSE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, auto_rpt_i;
  logic [15:0] page_i;
  logic        pulse_o, busy_o, done_o;
  int          checks = 0, failures = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  flp_burst_tx #(
    .SLOT_CYCLES(SLOT), .PULSE_CYCLES(PULSE), .REPEAT_CYCLES(RPT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
    .auto_rpt_i(auto_rpt_i), .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic exp_pulse(input logic [15:0] pg, input int t);
    int s = t / SLOT;
    int c = t % SLOT;
    if (c >= PULSE) return 1'b0;
    if (s % 2 == 0) return 1'b1;
    return pg[s / 2];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at offset 0 of the new burst
  task automatic launch(input logic [15:0] pg);
    start_i = 1'b1;
    page_i  = pg;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // starts at offset 0, returns at offset BLEN (the done cycle)
  task automatic capture(input logic [15:0] pg, input bit disturb);
    int bad_clk = 0, bad_dat = 0, bad_busy = 0;
    for (int t = 0; t < BLEN; t++) begin
      if (pulse_o !== exp_pulse(pg, t)) begin
        if ((t / SLOT) % 2 == 0) bad_clk++;
        else                     bad_dat++;
      end
      if (busy_o !== 1'b1 || done_o !== 1'b0) bad_busy++;
      if (disturb) begin
        page_i  = 16'($urandom);
        start_i = 1'($urandom);
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    // R1 R2 timing pulses
    check(bad_clk == 0, "R1 R2", bad_clk, 0);
    // R3 data pulses; with disturbance also R4 and R5
    check(bad_dat == 0, disturb ? "R4 R5" : "R3", bad_dat, 0);
    // R6 busy window
    check(bad_busy == 0, "R6", bad_busy, 0);
    // R7 done strobe after busy
    check(busy_o === 1'b0 && done_o === 1'b1, "R7", {busy_o, done_o}, 1);
  endtask

  initial begin
    logic [15:0] pg, pg2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; auto_rpt_i = 1'b0; page_i = 16'h0;
    repeat (3) @(negedge clk);
    // R10 in reset
    check({pulse_o, busy_o, done_o} === 3'b000, "R10", {pulse_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({pulse_o, busy_o, done_o} === 3'b000, "R10", {pulse_o, busy_o, done_o}, 0);

    // directed corner pages, chained back to back in the done cycle (R7)
    launch(16'h0000); capture(16'h0000, 0);
    launch(16'hFFFF);
    check(busy_o === 1'b1, "R7", busy_o, 1);
    capture(16'hFFFF, 0);
    launch(16'h0001); capture(16'h0001, 0);
    launch(16'h8000); capture(16'h8000, 0);

    // random pages with mid-burst page changes and ignored starts
    for (int k = 0; k < 6; k++) begin
      pg = 16'($urandom);
      launch(pg);
      capture(pg, k % 2 == 1);
      // R5 no extra burst from starts seen while busy
      @(negedge clk);
      check(busy_o === 1'b0, "R5", busy_o, 0);
    end

    // auto repeat: page on input when interval expires is sent (R8)
    auto_rpt_i = 1'b1;
    pg  = 16'($urandom);
    pg2 = 16'($urandom);
    launch(pg);
    page_i = pg2;
    capture(pg, 0);
    begin
      int early = 0;
      for (int t = BLEN; t < RPT; t++) begin
        if (busy_o !== 1'b0) early++;
        @(negedge clk);
      end
      check(early == 0, "R8", early, 0);
    end
    check(busy_o === 1'b1 && pulse_o === 1'b1, "R8", {busy_o, pulse_o}, 3);
    auto_rpt_i = 1'b0;
    capture(pg2, 0);
    begin
      int extra = 0;
      for (int t = 0; t < 2 * RPT; t++) begin
        if (busy_o !== 1'b0) extra++;
        @(negedge clk);
      end
      // R9 no burst once repeat is off
      check(extra == 0, "R9", extra, 0);
    end

    // start in the same cycle the interval expires (R11)
    auto_rpt_i = 1'b1;
    pg  = 16'($urandom);
    pg2 = 16'($urandom);
    launch(pg);
    capture(pg, 0);
    for (int t = BLEN; t < RPT - 1; t++) @(negedge clk);
    check(busy_o === 1'b0, "R11", busy_o, 0);
    launch(pg2);
    auto_rpt_i = 1'b0;
    check(busy_o === 1'b1, "R11", busy_o, 1);
    capture(pg2, 0);
    begin
      int extra = 0;
      for (int t = 0; t < RPT + 20; t++) begin
        if (busy_o !== 1'b0) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R11", extra, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule